// File: doc/BRIEF.md
# Serial Flash Slave with Write Protection

This block acts as the slave side of a four-wire serial flash. Commands, 24-bit addresses and data arrive most significant bit first on a serial input. Read data and status leave on a serial output. A chip-select frames each command. A pause input can freeze a transfer part way through, and it then resumes where it stopped. The memory is a small array of sectors held in registers, and every sector starts erased (0xFF). Programming can only clear bits. Erase works on a single sector or on the whole array.

All serial pins are sampled by the system clock `clk_i`, which must run several times faster than the serial clock. A program or erase does not change the array when the command ends. The block reports busy for a configurable number of system cycles and changes the array in the last of those cycles. Three controls guard against unwanted writes: the write-enable latch, the block-protect field and the status-lock bit. The status-lock bit is combined with the write-protect pin.

Top module: `flash_spi_slave`

## Requirements
- R1: Input bits are taken on the rising edge of `sck_i` and output bits change after the falling edge, most significant bit first. Read (0x03) followed by a 3-byte address returns bytes starting at that address. The address increments after each byte and wraps over the array.
- R2: While `cs_ni` is high, `sdo_oe_o` is low. It is high while a valid selection is active and the transfer is not paused.
- R3: While `hold_ni` is low with `cs_ni` low, `sdo_oe_o` is low, `sdo_o` holds its value, and `sck_i` and `sdi_i` are ignored. When `hold_ni` returns high, the transfer continues from the same bit.
- R4: After reset, no command is decoded until `cs_ni` goes from high to low. A selection that is already low when reset is released is ignored.
- R5: The status byte holds busy in bit 0, the write-enable latch in bit 1, the protect field in bits 4:2 and the status-lock bit in bit 7. Bits 6:5 read 0 and reset gives 0x00. Read-status (0x05) returns the status byte again for every further byte clocked.
- R6: Write-enable (0x06) sets the latch and write-disable (0x04) clears it, each once its opcode byte completes. Program, erase and status-write opcodes are ignored while the latch is clear.
- R7: Page program (0x02) stores each data byte as old AND new. The column wraps inside the 256-byte page of the start address.
- R8: A program or erase starts only if `cs_ni` rises after a whole number of bytes. Otherwise it is dropped, the array is unchanged and the latch stays set.
- R9: Sector erase (0xD8 plus an address) sets every byte of the addressed sector to 0xFF. Bulk erase (0xC7) sets every byte of the array to 0xFF.
- R10: A started program or erase holds busy for BUSY_CYCLES system cycles. During that time only read-status is decoded. The write-enable latch clears when busy ends.
- R11: A protect field value n>0 guards the top min(2^(n-1), SECTORS) sectors, and 0 guards none. Program or sector erase aimed at a guarded sector is dropped, and so is bulk erase when the field is non-zero. In each case the latch stays set.
- R12: Write-status (0x01) writes data bit 7 into the status-lock bit and data bits 4:2 into the protect field, then clears the latch. It is refused when `wp_ni` is low and the status-lock bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low chip select |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low transfer pause |
| wp_ni | input | 1 | Active-low write-protect pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` (low means high impedance) |

## Verification
The properties assume that the serial pins are already synchronous to `clk_i`. They also assume each level of `sck_i` lasts at least two system cycles, so that every serial edge is seen exactly once. The stimulus changes all pins only on the falling edge of `clk_i`, keeps each serial half-period three or more system cycles long, and changes `hold_ni` only while `sck_i` is low. The busy window is set far longer than a status poll, so that commands issued during an operation are known to arrive while busy is still high. `wp_ni` never changes between a write-status opcode and its data byte.

// File: rtl/flash_pkg.sv
package flash_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERA = 8'hD8;
  localparam logic [7:0] OP_BERA = 8'hC7;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_READ,
    ST_STAT,
    ST_WRSR,
    ST_PROG,
    ST_WAIT,
    ST_SKIP
  } st_e;

  typedef enum logic [1:0] {
    JOB_NONE,
    JOB_PROG,
    JOB_SECT,
    JOB_BULK
  } job_e;

endpackage

// File: rtl/flash_spi_phy.sv
module flash_spi_phy (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic       sdi_i,
  input  logic       hold_ni,
  input  logic       tx_load_i,
  input  logic [7:0] tx_byte_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       sel_start_o,
  output logic       sel_end_o,
  output logic       boundary_o,
  output logic       sdo_o,
  output logic       sdo_oe_o
);

  logic       sck_q, cs_q, sess_q, tx_pend_q;
  logic [2:0] bit_q;
  logic [6:0] sh_q;
  logic [7:0] tx_q, tx_nxt_q;
  logic       live, sck_rise, sck_fall, cs_fall, cs_rise;

  // cs_q resets low so a select held low across reset never opens a session
  assign cs_fall  = cs_q & ~cs_ni;
  assign cs_rise  = ~cs_q & cs_ni;
  assign live     = sess_q & ~cs_ni & hold_ni;
  assign sck_rise = live & sck_i & ~sck_q;
  assign sck_fall = live & ~sck_i & sck_q;

  assign byte_vld_o  = sck_rise & (bit_q == 3'd7);
  assign byte_o      = {sh_q, sdi_i};
  assign sel_start_o = cs_fall;
  assign sel_end_o   = cs_rise & sess_q;
  assign boundary_o  = (bit_q == 3'd0);
  assign sdo_o       = tx_q[7];
  assign sdo_oe_o    = live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b0;
      sess_q    <= 1'b0;
      bit_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      tx_nxt_q  <= '0;
      tx_pend_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_fall) begin
        sess_q    <= 1'b1;
        bit_q     <= '0;
        tx_pend_q <= 1'b0;
      end else if (cs_ni) begin
        sess_q <= 1'b0;
      end
      if (sck_rise) begin
        bit_q <= bit_q + 3'd1;
        sh_q  <= {sh_q[5:0], sdi_i};
      end
      if (sck_fall) begin
        if (tx_pend_q) begin
          tx_q      <= tx_nxt_q;
          tx_pend_q <= 1'b0;
        end else begin
          tx_q <= {tx_q[6:0], 1'b0};
        end
      end
      if (tx_load_i) begin
        tx_nxt_q  <= tx_byte_i;
        tx_pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int SECTORS    = 4,
  parameter int SECT_BYTES = 256,
  parameter int PAGE_BYTES = 256,
  localparam int DEPTH     = SECTORS * SECT_BYTES,
  localparam int AW        = $clog2(DEPTH),
  localparam int PAGE_AW   = $clog2(PAGE_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               buf_init_i,
  input  logic               buf_we_i,
  input  logic [PAGE_AW-1:0] buf_col_i,
  input  logic [7:0]         buf_data_i,
  input  logic               commit_i,
  input  job_e               job_i,
  input  logic [AW-1:0]      tgt_i
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] buf_q [PAGE_BYTES];
  int         pg_idx, sec_idx;

  assign rd_data_o = mem_q[rd_addr_i];

  always_comb begin
    pg_idx  = int'(tgt_i) / PAGE_BYTES;
    sec_idx = int'(tgt_i) / SECT_BYTES;
  end

  // page staging buffer: unwritten columns stay 0xFF so AND leaves them intact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (buf_init_i) begin
      for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
    end else if (buf_we_i) begin
      buf_q[buf_col_i] <= buf_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        case (job_i)
          JOB_PROG: if (i / PAGE_BYTES == pg_idx) mem_q[i] <= mem_q[i] & buf_q[i % PAGE_BYTES];
          JOB_SECT: if (i / SECT_BYTES == sec_idx) mem_q[i] <= 8'hFF;
          JOB_BULK: mem_q[i] <= 8'hFF;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int SECTORS     = 4,
  parameter int SECT_BYTES  = 256,
  parameter int PAGE_BYTES  = 256,
  parameter int BUSY_CYCLES = 64,
  localparam int DEPTH      = SECTORS * SECT_BYTES,
  localparam int AW         = $clog2(DEPTH),
  localparam int PAGE_AW    = $clog2(PAGE_BYTES),
  localparam int BW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic               sel_start_i,
  input  logic               sel_end_i,
  input  logic               boundary_i,
  input  logic               wp_ni,
  input  logic [7:0]         rd_data_i,
  output logic               tx_load_o,
  output logic [7:0]         tx_byte_o,
  output logic [AW-1:0]      rd_addr_o,
  output logic               buf_init_o,
  output logic               buf_we_o,
  output logic [PAGE_AW-1:0] buf_col_o,
  output logic [7:0]         buf_data_o,
  output logic               commit_o,
  output job_e               job_o,
  output logic [AW-1:0]      tgt_o,
  output logic [7:0]         status_o
);

  st_e           st_q, after_q;
  job_e          job_q;
  logic [AW-1:0] adr_q, tgt_q, adr_in;
  logic [1:0]    acnt_q;
  logic          got_q, wel_q, srp_q;
  logic [2:0]    bp_q;
  logic [BW-1:0] busy_q;
  logic          busy, sr_locked, job_prot, start;
  int            pcount, tsec;

  assign busy      = (busy_q != '0);
  assign status_o  = {srp_q, 2'b00, bp_q, wel_q, busy};
  assign sr_locked = srp_q & ~wp_ni;
  assign adr_in    = AW'({adr_q, byte_i});
  assign commit_o  = (busy_q == BW'(1));
  assign job_o     = job_q;
  assign tgt_o     = tgt_q;

  // protected region: top min(2^(bp-1), SECTORS) sectors
  always_comb begin
    pcount = 0;
    if (bp_q != 3'd0) pcount = 1 << (int'(bp_q) - 1);
    if (pcount > SECTORS) pcount = SECTORS;
    tsec     = int'(tgt_q) / SECT_BYTES;
    job_prot = (job_q == JOB_BULK) ? (bp_q != 3'd0) : (tsec >= SECTORS - pcount);
  end

  assign start = sel_end_i & boundary_i & ~job_prot &
                 (((st_q == ST_PROG) & got_q) | (st_q == ST_WAIT));

  always_comb begin
    tx_load_o = 1'b0;
    tx_byte_o = status_o;
    rd_addr_o = (st_q == ST_ADDR) ? adr_in : adr_q + AW'(1);
    if (byte_vld_i) begin
      case (st_q)
        ST_CMD:  tx_load_o = (byte_i == OP_RDSR);
        ST_STAT: tx_load_o = 1'b1;
        ST_ADDR: begin
          tx_load_o = (acnt_q == 2'd2) && (after_q == ST_READ);
          tx_byte_o = rd_data_i;
        end
        ST_READ: begin
          tx_load_o = 1'b1;
          tx_byte_o = rd_data_i;
        end
        default: ;
      endcase
    end
  end

  assign buf_init_o = byte_vld_i & (st_q == ST_ADDR) & (acnt_q == 2'd2) & (after_q == ST_PROG);
  assign buf_we_o   = byte_vld_i & (st_q == ST_PROG);
  assign buf_col_o  = adr_q[PAGE_AW-1:0];
  assign buf_data_o = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CMD;
      after_q <= ST_READ;
      job_q   <= JOB_NONE;
      adr_q   <= '0;
      tgt_q   <= '0;
      acnt_q  <= '0;
      got_q   <= 1'b0;
      wel_q   <= 1'b0;
      srp_q   <= 1'b0;
      bp_q    <= '0;
      busy_q  <= '0;
    end else begin
      if (busy) begin
        busy_q <= busy_q - BW'(1);
        if (commit_o) wel_q <= 1'b0;
      end
      if (sel_start_i) begin
        st_q <= ST_CMD;
      end else if (sel_end_i) begin
        st_q <= ST_CMD;
        if (start) busy_q <= BW'(BUSY_CYCLES);
      end else if (byte_vld_i) begin
        case (st_q)
          ST_CMD: begin
            st_q <= ST_SKIP;
            if (!busy || byte_i == OP_RDSR) begin
              case (byte_i)
                OP_WREN: wel_q <= 1'b1;
                OP_WRDI: wel_q <= 1'b0;
                OP_RDSR: st_q <= ST_STAT;
                OP_WRSR: if (wel_q && !sr_locked) st_q <= ST_WRSR;
                OP_READ: begin
                  after_q <= ST_READ;
                  acnt_q  <= '0;
                  st_q    <= ST_ADDR;
                end
                OP_PROG: if (wel_q) begin
                  after_q <= ST_PROG;
                  acnt_q  <= '0;
                  st_q    <= ST_ADDR;
                end
                OP_SERA: if (wel_q) begin
                  after_q <= ST_WAIT;
                  acnt_q  <= '0;
                  st_q    <= ST_ADDR;
                end
                OP_BERA: if (wel_q) begin
                  job_q <= JOB_BULK;
                  st_q  <= ST_WAIT;
                end
                default: ;
              endcase
            end
          end
          ST_ADDR: begin
            adr_q  <= adr_in;
            acnt_q <= acnt_q + 2'd1;
            if (acnt_q == 2'd2) begin
              tgt_q <= adr_in;
              case (after_q)
                ST_PROG: begin
                  st_q  <= ST_PROG;
                  got_q <= 1'b0;
                  job_q <= JOB_PROG;
                end
                ST_WAIT: begin
                  st_q  <= ST_WAIT;
                  job_q <= JOB_SECT;
                end
                default: st_q <= ST_READ;
              endcase
            end
          end
          ST_READ: adr_q <= adr_q + AW'(1);
          ST_PROG: begin
            got_q                <= 1'b1;
            adr_q[PAGE_AW-1:0]   <= adr_q[PAGE_AW-1:0] + PAGE_AW'(1);
          end
          ST_WRSR: begin
            if (!sr_locked) begin
              srp_q <= byte_i[7];
              bp_q  <= byte_i[4:2];
              wel_q <= 1'b0;
            end
            st_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_spi_slave.sv
module flash_spi_slave
  import flash_pkg::*;
#(
  parameter int SECTORS     = 4,
  parameter int SECT_BYTES  = 256,
  parameter int PAGE_BYTES  = 256,
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic sdi_i,
  input  logic hold_ni,
  input  logic wp_ni,
  output logic sdo_o,
  output logic sdo_oe_o
);

  localparam int DEPTH   = SECTORS * SECT_BYTES;
  localparam int AW      = $clog2(DEPTH);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);

  logic               byte_vld, sel_start, sel_end, boundary, tx_load;
  logic [7:0]         byte_w, tx_byte, rd_data, buf_data, status_w;
  logic [AW-1:0]      rd_addr, tgt;
  logic               buf_init, buf_we, commit;
  logic [PAGE_AW-1:0] buf_col;
  job_e               job;

  flash_spi_phy u_phy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (sck_i),
    .cs_ni       (cs_ni),
    .sdi_i       (sdi_i),
    .hold_ni     (hold_ni),
    .tx_load_i   (tx_load),
    .tx_byte_i   (tx_byte),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_w),
    .sel_start_o (sel_start),
    .sel_end_o   (sel_end),
    .boundary_o  (boundary),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  flash_ctrl #(
    .SECTORS     (SECTORS),
    .SECT_BYTES  (SECT_BYTES),
    .PAGE_BYTES  (PAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_w),
    .sel_start_i (sel_start),
    .sel_end_i   (sel_end),
    .boundary_i  (boundary),
    .wp_ni       (wp_ni),
    .rd_data_i   (rd_data),
    .tx_load_o   (tx_load),
    .tx_byte_o   (tx_byte),
    .rd_addr_o   (rd_addr),
    .buf_init_o  (buf_init),
    .buf_we_o    (buf_we),
    .buf_col_o   (buf_col),
    .buf_data_o  (buf_data),
    .commit_o    (commit),
    .job_o       (job),
    .tgt_o       (tgt),
    .status_o    (status_w)
  );

  flash_array #(
    .SECTORS    (SECTORS),
    .SECT_BYTES (SECT_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .buf_init_i (buf_init),
    .buf_we_i   (buf_we),
    .buf_col_i  (buf_col),
    .buf_data_i (buf_data),
    .commit_i   (commit),
    .job_i      (job),
    .tgt_i      (tgt)
  );

endmodule

// File: rtl/flash_spi_sva.sv
module flash_spi_sva #(
  parameter int BUSY_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic hold_ni,
  input logic wp_ni,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic srp_i,
  input logic wel_i,
  input logic busy_i
);

  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_i) busy_len_q <= busy_len_q + 32'd1;
    else             busy_len_q <= '0;
  end

  p_desel_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !sdo_oe_o);

  p_hold_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_ni |-> !sdo_oe_o);

  p_hold_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni && !cs_ni) |=> $stable(sdo_o));

  p_busy_needs_wel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> wel_i);

  p_busy_len_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (busy_len_q == 32'(BUSY_CYCLES)));

  p_wel_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !wel_i);

  p_lock_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && srp_i) |=> srp_i);

endmodule

bind flash_spi_slave flash_spi_sva #(.BUSY_CYCLES(BUSY_CYCLES)) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .hold_ni  (hold_ni),
  .wp_ni    (wp_ni),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .srp_i    (status_w[7]),
  .wel_i    (status_w[1]),
  .busy_i   (status_w[0])
);

// File: tb/sim_flash_spi_slave.sv
module sim_flash_spi_slave;

  localparam int BUSY  = 300;
  localparam int DEPTH = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic sdo, sdo_oe;

  always #10 clk = ~clk;

  flash_spi_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .sdi_i(sdi),
    .hold_ni(hold_n), .wp_ni(wp_n), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] model [DEPTH];
  logic [7:0] rx_val;
  event       rx_ev;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_t e;
    e.tag = tag;
    e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expectation per captured byte
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) begin
      n_run++; n_fail++;
      $display("FAIL R1: unexpected byte %h expected none", rx_val);
    end else begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, rx_val, e.val);
    end
  end

  task automatic hold_pause();
    hold_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3 oe off in hold", {7'd0, sdo_oe}, 8'h00);
    for (int k = 0; k < 3; k++) begin
      sdi = k[0];
      sck = 1'b1; repeat (3) @(negedge clk);
      sck = 1'b0; repeat (3) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit cap, input int hold_at = -1, input int nbits = 8);
    logic [7:0] r = '0;
    for (int i = 0; i < nbits; i++) begin
      if (i == hold_at) hold_pause();
      sdi = tx[7-i];
      repeat (2) @(negedge clk);
      r = {r[6:0], sdo};
      sck = 1'b1; repeat (3) @(negedge clk);
      sck = 1'b0; repeat (2) @(negedge clk);
    end
    if (cap) begin
      rx_val = r;
      ->rx_ev;
      @(negedge clk);
    end
  endtask

  task automatic sel();   cs_n = 1'b0; repeat (2) @(negedge clk); endtask
  task automatic desel(); repeat (2) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk); endtask

  task automatic op1(input logic [7:0] op);
    sel(); xfer(op, 0); desel();
  endtask

  task automatic send_addr(input logic [23:0] a);
    xfer(a[23:16], 0); xfer(a[15:8], 0); xfer(a[7:0], 0);
  endtask

  task automatic rdsr(input string tag, input logic [7:0] v, input int n = 1);
    for (int i = 0; i < n; i++) expect_byte(tag, v);
    sel(); xfer(8'h05, 0);
    for (int i = 0; i < n; i++) xfer(8'h00, 1);
    desel();
  endtask

  task automatic rd(input string tag, input logic [23:0] a, input int n, input int hold_at = -1);
    for (int i = 0; i < n; i++) expect_byte(tag, model[(int'(a) + i) % DEPTH]);
    sel(); xfer(8'h03, 0); send_addr(a);
    for (int i = 0; i < n; i++) xfer(8'h00, 1, (i == 0) ? hold_at : -1);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel(); xfer(8'h01, 0); xfer(v, 0); desel();
  endtask

  task automatic pp(input logic [23:0] a, input logic [7:0] d[$], input int extra = 0);
    sel(); xfer(8'h02, 0); send_addr(a);
    foreach (d[i]) xfer(d[i], 0);
    if (extra > 0) xfer(8'h00, 0, -1, extra);
    desel();
  endtask

  task automatic model_pp(input int a, input logic [7:0] d[$]);
    int base = a & ~255;
    foreach (d[i]) model[base + ((a + i) & 255)] &= d[i];
  endtask

  task automatic wait_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    cs_n = 1'b1;
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: selection low across reset is ignored
    xfer(8'h06, 0);
    chk("R4 oe off before select edge", {7'd0, sdo_oe}, 8'h00);
    desel();
    chk("R2 oe off while deselected", {7'd0, sdo_oe}, 8'h00);
    rdsr("R4 R5 reset status", 8'h00);
    sel();
    chk("R2 oe on while selected", {7'd0, sdo_oe}, 8'h01);
    desel();

    op1(8'h06);
    rdsr("R6 R5 wel set, repeated status", 8'h02, 2);
    op1(8'h04);
    rdsr("R6 wel cleared", 8'h00);
    pp(24'h000010, '{8'hA5});
    wait_busy();
    rd("R6 program without wel ignored", 24'h000010, 1);

    op1(8'h06);
    pp(24'h000010, '{8'hF0, 8'h5A});
    model_pp(16, '{8'hF0, 8'h5A});
    op1(8'h04);
    rdsr("R10 busy with wel, wrdi ignored", 8'h03);
    wait_busy();
    rdsr("R10 wel clears at end", 8'h00);
    rd("R1 R7 programmed bytes", 24'h000010, 2);

    op1(8'h06);
    pp(24'h000010, '{8'h3C});
    model_pp(16, '{8'h3C});
    wait_busy();
    rd("R7 and-programming", 24'h000010, 1);

    op1(8'h06);
    pp(24'h0001FE, '{8'h11, 8'h22, 8'h33});
    model_pp(16'h1FE, '{8'h11, 8'h22, 8'h33});
    wait_busy();
    rd("R7 R1 page wrap and read increment", 24'h0001FE, 3);
    rd("R7 wrapped column", 24'h000100, 1);

    op1(8'h06);
    pp(24'h000020, '{8'h00}, 4);
    wait_busy();
    rd("R8 partial byte drops program", 24'h000020, 1);
    rdsr("R8 wel kept", 8'h02);
    op1(8'h04);

    rd("R3 hold mid-byte resumes", 24'h000010, 2, 3);

    op1(8'h06);
    sel(); xfer(8'hD8, 0); send_addr(24'h000100); desel();
    for (int i = 256; i < 512; i++) model[i] = 8'hFF;
    wait_busy();
    rd("R9 sector erased", 24'h000100, 1);
    rd("R9 sector erased end", 24'h0001FF, 1);
    rd("R9 other sector kept", 24'h000010, 1);

    op1(8'h06);
    wrsr(8'h04);
    rdsr("R12 R5 protect field written", 8'h04);
    op1(8'h06);
    pp(24'h000300, '{8'h00});
    wait_busy();
    rdsr("R11 refused keeps wel", 8'h06);
    rd("R11 guarded sector unchanged", 24'h000300, 1);
    pp(24'h000200, '{8'h00});
    model_pp(16'h200, '{8'h00});
    wait_busy();
    rd("R11 unguarded sector programmed", 24'h000200, 1);
    op1(8'h06);
    op1(8'hC7);
    wait_busy();
    rd("R11 bulk erase refused", 24'h000010, 1);
    op1(8'h04);

    op1(8'h06);
    wrsr(8'h84);
    rdsr("R12 lock bit set", 8'h84);
    wp_n = 1'b0;
    op1(8'h06);
    wrsr(8'h00);
    rdsr("R12 locked status refused", 8'h86);
    wp_n = 1'b1;
    wrsr(8'h00);
    rdsr("R12 unlocked write", 8'h00);

    op1(8'h06);
    op1(8'hC7);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    rdsr("R10 busy during bulk", 8'h03);
    wait_busy();
    rd("R9 bulk erased", 24'h000010, 1);
    rd("R9 bulk erased hi", 24'h000200, 1);

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R1: %0d bytes not seen, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule